// File: doc/BRIEF.md
# Multiply-Accumulate Instruction Unit

This unit recognises and executes the 32-bit multiply and multiply-accumulate instruction of a RISC core. It compares the instruction word against a fixed bit pattern and takes its register indices from fixed fields. It works out the low 32 bits of a product, optionally plus an addend, and returns the result together with a destination index, write enables and new flags. The condition check, the register file and the issue logic belong to the surrounding core. The core feeds in a pass signal, the current flags and the three source operands.

The match signal and the three source indices are combinational from the instruction word. The core uses them to read the register file and to give this pattern priority over the general data-processing pattern. Results are registered and appear one cycle after an issue strobe, marked by a one-cycle done pulse. Only the negative and zero flags can change. Carry and overflow always pass through untouched.

Top module: `mac_exec_unit`

## Requirements
- R1: `match` is 1 exactly when `(instr & 32'h0FC000F0) == 32'h00000090`, combinationally from `instr`.
- R2: The source indices are combinational fields of `instr`: `rm_idx` = bits [3:0], `rs_idx` = bits [11:8], `rn_idx` = bits [15:12]. The registered `dst_idx` is bits [19:16] of the issued word.
- R3: With instr bit 21 (accumulate) at 0, `result` is the low 32 bits of `rm_data * rs_data`.
- R4: With instr bit 21 at 1, `result` is `(rm_data * rs_data + rn_data)` modulo 2^32.
- R5: `done` is 1 in exactly the cycle after each cycle with `issue_vld` high. The results of that issue are valid while `done` is 1.
- R6: Flags are packed {N,Z,C,V} in bits [3:0]. On a matched, passing issue with instr bit 20 (set-flags) at 1, `flags_we` is 1, `flags_out[3]` is `result[31]`, and `flags_out[2]` is 1 exactly when `result` is zero.
- R7: `flags_out[1:0]` always equals the `flags_in[1:0]` of the issue. When bit 20 is 0, `flags_we` is 0.
- R8: With `cond_ok` low, `done` still pulses but `dst_we` and `flags_we` stay 0.
- R9: An issued word that does not match gives a `done` pulse with `dst_we` and `flags_we` at 0.
- R10: After synchronous reset, `done`, `dst_we`, `flags_we`, `result` and `flags_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_vld | input | 1 | Issue strobe for the current instruction |
| instr | input | 32 | Instruction word |
| cond_ok | input | 1 | Condition check passed |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| rm_data | input | 32 | Multiplicand operand |
| rs_data | input | 32 | Multiplier operand |
| rn_data | input | 32 | Addend operand |
| match | output | 1 | Instruction matches the multiply pattern |
| rm_idx | output | 4 | Multiplicand register index |
| rs_idx | output | 4 | Multiplier register index |
| rn_idx | output | 4 | Addend register index |
| done | output | 1 | Result valid pulse |
| dst_idx | output | 4 | Destination register index |
| dst_we | output | 1 | Destination write enable |
| result | output | 32 | Product or product plus addend |
| flags_out | output | 4 | Updated flags {N,Z,C,V} |
| flags_we | output | 1 | Flag write enable |

## Verification
`match` and the source indices have zero latency. The bench checks them with inputs settled, before any clock edge. Every other output is due exactly one rising edge after the issue. So the bench drives an issue on a falling edge, lets one rising edge pass, and samples on the following falling edge before it changes any input. The checker asserts the same one-cycle relation with `|=>` against the issued inputs.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int INSTR_W = 32;
  localparam logic [INSTR_W-1:0] MAC_MASK  = 32'h0FC0_00F0;
  localparam logic [INSTR_W-1:0] MAC_PATTN = 32'h0000_0090;
  localparam int ACC_BIT  = 21;
  localparam int SETF_BIT = 20;
  localparam int RD_LSB = 16;
  localparam int RN_LSB = 12;
  localparam int RS_LSB = 8;
  localparam int RM_LSB = 0;
  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;

  typedef struct packed {
    logic       acc;
    logic       setf;
    logic [3:0] rd;
    logic [3:0] rn;
    logic [3:0] rs;
    logic [3:0] rm;
  } mac_fields_t;
endpackage

// File: rtl/mac_decode.sv
module mac_decode
  import mac_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output logic               hit,
  output mac_fields_t        fields
);
  always_comb begin
    hit         = (instr & MAC_MASK) == MAC_PATTN;
    fields.acc  = instr[ACC_BIT];
    fields.setf = instr[SETF_BIT];
    fields.rd   = instr[RD_LSB +: 4];
    fields.rn   = instr[RN_LSB +: 4];
    fields.rs   = instr[RS_LSB +: 4];
    fields.rm   = instr[RM_LSB +: 4];
  end
endmodule

// File: rtl/mac_arith.sv
module mac_arith #(
  parameter int XLEN = 32
) (
  input  logic            acc,
  input  logic [XLEN-1:0] mcand,
  input  logic [XLEN-1:0] mplier,
  input  logic [XLEN-1:0] addend,
  output logic [XLEN-1:0] sum
);
  logic [XLEN-1:0] prod_lo;
  always_comb begin
    prod_lo = mcand * mplier;
    sum     = prod_lo + (acc ? addend : '0);
  end
endmodule

// File: rtl/mac_flags.sv
module mac_flags
  import mac_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            upd,
  input  logic [XLEN-1:0] value,
  input  logic [3:0]      cur,
  output logic [3:0]      nxt
);
  always_comb begin
    nxt         = cur;
    if (upd) begin
      nxt[FLAG_N] = value[XLEN-1];
      nxt[FLAG_Z] = (value == '0);
    end
  end
endmodule

// File: rtl/mac_exec_unit.sv
module mac_exec_unit
  import mac_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int RIDX_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_vld,
  input  logic [INSTR_W-1:0] instr,
  input  logic              cond_ok,
  input  logic [3:0]        flags_in,
  input  logic [XLEN-1:0]   rm_data,
  input  logic [XLEN-1:0]   rs_data,
  input  logic [XLEN-1:0]   rn_data,
  output logic              match,
  output logic [RIDX_W-1:0] rm_idx,
  output logic [RIDX_W-1:0] rs_idx,
  output logic [RIDX_W-1:0] rn_idx,
  output logic              done,
  output logic [RIDX_W-1:0] dst_idx,
  output logic              dst_we,
  output logic [XLEN-1:0]   result,
  output logic [3:0]        flags_out,
  output logic              flags_we
);
  mac_fields_t     fld;
  logic            hit;
  logic            commit;
  logic [XLEN-1:0] sum;
  logic [3:0]      flags_nxt;

  mac_decode u_dec (.instr(instr), .hit(hit), .fields(fld));

  mac_arith #(.XLEN(XLEN)) u_arith (
    .acc(fld.acc), .mcand(rm_data), .mplier(rs_data),
    .addend(rn_data), .sum(sum)
  );

  assign commit = hit & cond_ok;

  mac_flags #(.XLEN(XLEN)) u_flags (
    .upd(commit & fld.setf), .value(sum), .cur(flags_in), .nxt(flags_nxt)
  );

  assign match  = hit;
  assign rm_idx = fld.rm;
  assign rs_idx = fld.rs;
  assign rn_idx = fld.rn;

  always_ff @(posedge clk) begin
    if (rst) begin
      done      <= 1'b0;
      dst_we    <= 1'b0;
      flags_we  <= 1'b0;
      dst_idx   <= '0;
      result    <= '0;
      flags_out <= '0;
    end else begin
      done     <= issue_vld;
      dst_we   <= issue_vld & commit;
      flags_we <= issue_vld & commit & fld.setf;
      if (issue_vld) begin
        dst_idx   <= fld.rd;
        result    <= sum;
        flags_out <= flags_nxt;
      end
    end
  end
endmodule

// File: rtl/mac_exec_unit_chk.sv
module mac_exec_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        issue_vld,
  input logic [31:0] instr,
  input logic        cond_ok,
  input logic [3:0]  flags_in,
  input logic        match,
  input logic        done,
  input logic        dst_we,
  input logic [31:0] result,
  input logic [3:0]  flags_out,
  input logic        flags_we
);
  // R5
  done_follows_issue_chk: assert property (@(posedge clk) disable iff (rst)
    issue_vld |=> done);
  // R5
  done_only_after_issue_chk: assert property (@(posedge clk) disable iff (rst)
    !issue_vld |=> !done);
  // R8
  cond_fail_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_vld && !cond_ok) |=> (!dst_we && !flags_we));
  // R9
  nomatch_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_vld && !match) |=> (!dst_we && !flags_we));
  // R7
  cv_passthru_chk: assert property (@(posedge clk) disable iff (rst)
    issue_vld |=> (flags_out[1:0] == $past(flags_in[1:0])));
  // R7
  no_setf_no_fwe_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_vld && !instr[20]) |=> !flags_we);
  // R6
  nz_update_chk: assert property (@(posedge clk) disable iff (rst)
    flags_we |-> (flags_out[3] == result[31] && flags_out[2] == (result == 32'd0)));
  // R5
  we_within_done_chk: assert property (@(posedge clk) disable iff (rst)
    (dst_we || flags_we) |-> done);
endmodule

bind mac_exec_unit mac_exec_unit_chk u_chk (
  .clk(clk), .rst(rst), .issue_vld(issue_vld), .instr(instr),
  .cond_ok(cond_ok), .flags_in(flags_in), .match(match), .done(done),
  .dst_we(dst_we), .result(result), .flags_out(flags_out), .flags_we(flags_we)
);

// File: tb/mac_exec_unit_tb.sv
module mac_exec_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue_vld = 1'b0;
  logic [31:0] instr = '0;
  logic        cond_ok = 1'b0;
  logic [3:0]  flags_in = '0;
  logic [31:0] rm_data = '0, rs_data = '0, rn_data = '0;
  logic        match, done, dst_we, flags_we;
  logic [3:0]  rm_idx, rs_idx, rn_idx, dst_idx, flags_out;
  logic [31:0] result;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_exec_unit dut_i (
    .clk(clk), .rst(rst), .issue_vld(issue_vld), .instr(instr),
    .cond_ok(cond_ok), .flags_in(flags_in), .rm_data(rm_data),
    .rs_data(rs_data), .rn_data(rn_data), .match(match), .rm_idx(rm_idx),
    .rs_idx(rs_idx), .rn_idx(rn_idx), .done(done), .dst_idx(dst_idx),
    .dst_we(dst_we), .result(result), .flags_out(flags_out), .flags_we(flags_we)
  );

  function automatic bit exp_match(input logic [31:0] w);
    return (w & 32'h0FC000F0) == 32'h00000090;
  endfunction

  function automatic logic [31:0] exp_result(input logic [31:0] w,
      input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
    logic [63:0] full;
    full = {32'd0, a} * {32'd0, b};
    if (w[21]) full = full + {32'd0, c};
    return full[31:0];
  endfunction

  function automatic logic [31:0] mk_mul(input logic [3:0] cc, input bit acc,
      input bit sf, input logic [3:0] d, input logic [3:0] n,
      input logic [3:0] s, input logic [3:0] m);
    return {cc, 6'b000000, acc, sf, d, n, s, 4'b1001, m};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_issue(input logic [31:0] w, input bit c, input logic [3:0] f,
      input logic [31:0] a, input logic [31:0] b, input logic [31:0] d);
    logic [31:0] er;
    bit m, pass;
    @(negedge clk);
    instr = w; cond_ok = c; flags_in = f; rm_data = a; rs_data = b; rn_data = d;
    issue_vld = 1'b1;
    #1;
    m = exp_match(w);
    chk(match == m, "R1 match", {31'd0, match}, {31'd0, m});
    chk({rn_idx, rs_idx, rm_idx} == {w[15:12], w[11:8], w[3:0]}, "R2 src idx",
        {20'd0, rn_idx, rs_idx, rm_idx}, {20'd0, w[15:12], w[11:8], w[3:0]});
    @(negedge clk);
    er = exp_result(w, a, b, d);
    pass = m && c;
    chk(done == 1'b1, "R5 done", {31'd0, done}, 32'd1);
    chk(flags_out[1:0] == f[1:0], "R7 C/V kept", {28'd0, flags_out}, {28'd0, f});
    if (!c && m) chk(!dst_we && !flags_we, "R8 cond fail", {30'd0, dst_we, flags_we}, 32'd0);
    if (!m) chk(!dst_we && !flags_we, "R9 no match", {30'd0, dst_we, flags_we}, 32'd0);
    if (pass) begin
      chk(dst_we == 1'b1, "R5 dst_we", {31'd0, dst_we}, 32'd1);
      chk(dst_idx == w[19:16], "R2 dst_idx", {28'd0, dst_idx}, {28'd0, w[19:16]});
      chk(result == er, w[21] ? "R4 mla" : "R3 mul", result, er);
      chk(flags_we == w[20], w[20] ? "R6 flags_we" : "R7 no flags_we",
          {31'd0, flags_we}, {31'd0, w[20]});
      if (w[20])
        chk(flags_out[3:2] == {er[31], er == 0}, "R6 N/Z",
            {30'd0, flags_out[3:2]}, {30'd0, er[31], er == 32'd0});
    end
    issue_vld = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R5 single pulse", {31'd0, done}, 32'd0);
  endtask

  initial begin
    int unsigned seed;
    seed = 32'd1357;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk({done, dst_we, flags_we} == 3'b000 && result == 0 && flags_out == 0,
        "R10 reset", result, 32'd0);
    rst = 1'b0;
    // R3 plain multiply, zero result sets Z
    run_issue(mk_mul(4'hE, 0, 1, 4'd2, 4'd3, 4'd4, 4'd5), 1, 4'b0011, 32'd0, 32'd77, 32'd9);
    // R3 wraparound, N from bit 31
    run_issue(mk_mul(4'hE, 0, 1, 4'd7, 4'd1, 4'd2, 4'd3), 1, 4'b0000,
              32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd5);
    run_issue(mk_mul(4'h0, 0, 1, 4'd1, 4'd0, 4'd0, 4'd0), 1, 4'b0101,
              32'h4000_0000, 32'd2, 32'd0);
    // R4 accumulate wrapping to zero
    run_issue(mk_mul(4'hE, 1, 1, 4'd15, 4'd14, 4'd13, 4'd12), 1, 4'b1110,
              32'd1, 32'hFFFF_FFFF, 32'd1);
    // R7 no set-flags
    run_issue(mk_mul(4'hE, 1, 0, 4'd6, 4'd6, 4'd6, 4'd6), 1, 4'b1010, 32'd3, 32'd5, 32'd7);
    // R8 condition fail
    run_issue(mk_mul(4'h1, 1, 1, 4'd3, 4'd4, 4'd5, 4'd6), 0, 4'b1111, 32'd2, 32'd2, 32'd2);
    // R9 near misses
    run_issue(32'hE000_0010, 1, 4'b0001, 32'd3, 32'd3, 32'd3);
    run_issue(32'hE040_0090, 1, 4'b0010, 32'd3, 32'd3, 32'd3);
    run_issue(32'hE00000B0, 1, 4'b0000, 32'd3, 32'd3, 32'd3);
    for (int i = 0; i < 300; i++) begin
      logic [31:0] w;
      if (i % 4 == 3) w = $urandom();
      else w = mk_mul(4'($urandom()), 1'($urandom()), 1'($urandom()), 4'($urandom()),
                      4'($urandom()), 4'($urandom()), 4'($urandom()));
      run_issue(w, 1'($urandom_range(0, 3) != 0), 4'($urandom()),
                $urandom(), $urandom(), $urandom());
    end
    // back-to-back issues
    @(negedge clk);
    instr = mk_mul(4'hE, 0, 0, 4'd9, 4'd0, 4'd1, 4'd2); cond_ok = 1;
    rm_data = 32'd6; rs_data = 32'd7; issue_vld = 1;
    @(negedge clk);
    chk(done && result == 32'd42, "R5 b2b first", result, 32'd42);
    instr = mk_mul(4'hE, 1, 0, 4'd8, 4'd0, 4'd1, 4'd2); rn_data = 32'd100;
    @(negedge clk);
    chk(done && result == 32'd142 && dst_idx == 4'd8, "R4 b2b second", result, 32'd142);
    issue_vld = 0;
    @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule